// File: doc/BRIEF.md
# Sensor Bus Scan Sequencer

This block drives a two-wire sensor/actuator bus with open-drain clock and data lines. It divides the system clock to one of four bus clock rates. Each frame starts with a short sync gap, then it walks the bit addresses from zero up to the configured frame length. A mapper outside the block receives the current address, the multiplex channel and a mux flag. The mapper returns the output bit for that address, and the block hands back every sampled input bit with a one-cycle strobe.

The block has two modes. In host mode each address takes two bus clock cycles: an input cycle, where the line is released and sampled, and an output cycle, where the host drives the line. In peer mode each address takes one bus clock cycle: the host drives its bit and reads back the wired-OR of its own drive and the field devices. Addresses in the top part of the frame form the multiplexed region. The multiplex channel rotates once per frame, so each channel of a multiplexed word is refreshed only once every channel-count frames.

The controller has four states. Idle holds both lines released. Sync holds the clock released for one half period and pulses `frame_start`. Low drives the clock line low. High releases it.

The transitions are as follows. Idle goes to Sync when `run_en` is high. Sync goes to Low when the divider ticks. Low goes to High when the divider ticks. High goes back to Low when the divider ticks and the address is not the last one. High goes to Sync when the divider ticks on the last bus cycle of the frame. From any state, a low `run_en` returns the block to Idle.

Top module: `scan_seq_top`

## Requirements
- R1: After reset, and while `run_en` stays low, the block keeps both lines released and raises neither `frame_start` nor `in_valid`.
- R2: One clock half period (Low, High and Sync each) lasts `max(1, SYS_CLK_HZ / (2*rate))` system cycles. The rate is selected by `cfg_speed`: 0 gives 16000 Hz, 1 gives 32000 Hz, 2 gives 50000 Hz and 3 gives 100000 Hz.
- R3: A frame covers `(cfg_size+1)*16` addresses, counting up from 0. `frame_start` pulses once per frame, in the first Sync cycle, while `bit_addr` is 0.
- R4: Host mode (`cfg_peer`=0) applies to each address in order.
  - In the first bus cycle, `out_req` is low, the data line is released, and `in_valid` pulses at the end of High.
  - In the second bus cycle, `out_req` is high and `bus_data_oe` equals `out_bit` for the whole cycle, and no sample is taken.
  - One frame has `2*frame_bits` clock low pulses.
- R5: Peer mode (`cfg_peer`=1) takes one bus cycle per address. The host drives `out_bit` for the whole cycle, and `in_bit` equals the line state, which is the wired-OR of the host and field drives. A line driven low reads as 1.
- R6: An address is multiplexed, and `bit_is_mux` is 1, when `cfg_mux_words` is non-zero and the address is at or above `frame_bits - 16*cfg_mux_words`, with the boundary clamped at 0. Non-multiplexed addresses report channel 0.
- R7: The channel is 0 in the first frame after a start. It advances by one at each frame boundary and wraps to 0 after `2 << cfg_depth` channels.
- R8: A configuration change is taken up only when the next Sync is entered. The frame in progress keeps its length, mode, rate and multiplex layout.
- R9: When `run_en` falls, both lines are released by the next cycle, no further frame starts, and the channel restarts at 0 on the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Scan enable; low stops the bus at once |
| cfg_speed | input | 2 | Bus clock rate select |
| cfg_size | input | 4 | Frame length in 16-bit words, minus one |
| cfg_peer | input | 1 | 1 = peer (wired-OR) mode, 0 = host mode |
| cfg_depth | input | 2 | Channel count code: 2 << value channels |
| cfg_mux_words | input | 4 | Number of 16-bit multiplexed words at the top of the frame |
| bus_clk_oe | output | 1 | Pull the bus clock line low |
| bus_data_oe | output | 1 | Pull the bus data line low |
| bus_data_in | input | 1 | Sensed data line level (0 = pulled low) |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| bit_addr | output | ADDR_W | Address being scanned |
| bit_chan | output | CH_W | Multiplex channel for the current address |
| bit_is_mux | output | 1 | Current address lies in the multiplexed region |
| out_req | output | 1 | Output phase: the block uses `out_bit` now |
| out_bit | input | 1 | Output value from the mapper for the current address |
| in_valid | output | 1 | One-cycle strobe when `in_bit` holds a sample |
| in_bit | output | 1 | Sampled bit (1 = line low) |

## Verification
The hardest state to reach is the frame boundary where a new configuration and a channel step take effect on the same edge. The hardest part is doing that while a previous frame is still running under the old settings. The bench gets there by changing the frame length a few cycles after a frame has started. It then compares the address count of that frame with the count of the following frame. Channel wrap is reached by running enough back-to-back short frames at the fastest rate. Each run of the top multiplexed word is checked against a bench-side channel sequence.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SYNC = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } scan_state_t;

    typedef struct packed {
        logic [1:0] speed;
        logic [3:0] size;
        logic       peer;
        logic [1:0] depth;
        logic [3:0] mux_words;
    } scan_cfg_t;

    function automatic int unsigned rate_hz(input logic [1:0] code);
        case (code)
            2'd0:    return 16000;
            2'd1:    return 32000;
            2'd2:    return 50000;
            default: return 100000;
        endcase
    endfunction

    function automatic int unsigned half_period(input int unsigned sys_hz, input logic [1:0] code);
        int unsigned q;
        q = sys_hz / (2 * rate_hz(code));
        return (q == 0) ? 1 : q;
    endfunction

endpackage

// File: rtl/scan_clkdiv.sv
`timescale 1ns/1ps
module scan_clkdiv
    import scan_seq_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] speed,
    output logic       tick
);
    localparam int unsigned TC_MAX = half_period(SYS_CLK_HZ, 2'd0);
    localparam int          CNT_W  = $clog2(TC_MAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tc_tab [4];
    logic [CNT_W-1:0] tc_sel;

    generate
        for (genvar g = 0; g < 4; g++) begin : g_tc
            localparam int unsigned TC_G = half_period(SYS_CLK_HZ, 2'(g));
            assign tc_tab[g] = CNT_W'(TC_G);
        end
    endgenerate

    assign tc_sel = tc_tab[speed];
    assign tick   = (cnt_q == tc_sel - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end

    // R2: the count never passes the selected terminal value
    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < tc_sel);

endmodule

// File: rtl/scan_addr_seq.sv
`timescale 1ns/1ps
module scan_addr_seq #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              peer,
    input  logic [ADDR_W:0]   frame_bits,
    output logic [ADDR_W-1:0] addr,
    output logic              out_phase,
    output logic              last
);
    logic [ADDR_W:0] last_addr;

    assign last_addr = frame_bits - {{ADDR_W{1'b0}}, 1'b1};
    assign last      = ({1'b0, addr} == last_addr) && (peer || out_phase);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            out_phase <= 1'b0;
        end else if (clear) begin
            addr      <= '0;
            out_phase <= 1'b0;
        end else if (step) begin
            if (peer || out_phase) begin
                addr      <= addr + {{(ADDR_W-1){1'b0}}, 1'b1};
                out_phase <= 1'b0;
            end else begin
                out_phase <= 1'b1;
            end
        end
    end

    // R3: the address stays inside the configured frame
    p_addr_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, addr} < frame_bits);

    // R5: peer mode never enters a separate output cycle
    p_peer_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        peer |-> !out_phase);

endmodule

// File: rtl/scan_chan_rot.sv
`timescale 1ns/1ps
module scan_chan_rot #(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            advance,
    input  logic [1:0]      depth,
    output logic [CH_W-1:0] chan
);
    logic [CH_W:0] n_ch;

    assign n_ch = (CH_W+1)'(2) << depth;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       chan <= '0;
        else if (clear)   chan <= '0;
        else if (advance) begin
            if (({1'b0, chan} + (CH_W+1)'(1)) >= n_ch) chan <= '0;
            else                                       chan <= chan + CH_W'(1);
        end
    end

endmodule

// File: rtl/scan_seq_top.sv
`timescale 1ns/1ps
module scan_seq_top
    import scan_seq_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 50_000_000,
    parameter int          ADDR_W     = 8,
    parameter int          CH_W       = 4,
    parameter int          WORD_BITS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [1:0]        cfg_speed,
    input  logic [3:0]        cfg_size,
    input  logic              cfg_peer,
    input  logic [1:0]        cfg_depth,
    input  logic [3:0]        cfg_mux_words,
    output logic              bus_clk_oe,
    output logic              bus_data_oe,
    input  logic              bus_data_in,
    output logic              frame_start,
    output logic [ADDR_W-1:0] bit_addr,
    output logic [CH_W-1:0]   bit_chan,
    output logic              bit_is_mux,
    output logic              out_req,
    input  logic              out_bit,
    output logic              in_valid,
    output logic              in_bit
);
    scan_state_t     state_q, state_d;
    scan_cfg_t       cfg_in, cfg_q;
    logic            tick, last, out_phase, enter_sync, drive_phase;
    logic            addr_clear, addr_step, chan_clear, chan_adv;
    logic [ADDR_W:0] frame_bits, mux_bits, mux_base;
    logic [CH_W-1:0] chan;
    logic [CH_W:0]   chan_lim;

    assign cfg_in = '{speed: cfg_speed, size: cfg_size, peer: cfg_peer,
                      depth: cfg_depth, mux_words: cfg_mux_words};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (!run_en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_SYNC;
                ST_SYNC: if (tick) state_d = ST_LOW;
                ST_LOW:  if (tick) state_d = ST_HIGH;
                ST_HIGH: if (tick) state_d = last ? ST_SYNC : ST_LOW;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign enter_sync = (state_d == ST_SYNC) && (state_q != ST_SYNC);

    // ---------------- frame-boundary configuration ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cfg_q <= '0;
        else if (enter_sync) cfg_q <= cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_start <= 1'b0;
        else        frame_start <= enter_sync;
    end

    assign frame_bits = (ADDR_W+1)'(({1'b0, cfg_q.size} + 5'd1) * WORD_BITS);
    assign mux_bits   = (ADDR_W+1)'(cfg_q.mux_words * WORD_BITS);
    assign mux_base   = (frame_bits > mux_bits) ? (frame_bits - mux_bits) : '0;

    // ---------------- sub-blocks ----------------
    scan_clkdiv #(.SYS_CLK_HZ(SYS_CLK_HZ)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart ((state_q == ST_IDLE) || enter_sync),
        .speed   (cfg_q.speed),
        .tick    (tick)
    );

    assign addr_clear = (state_d != ST_LOW) && (state_d != ST_HIGH);
    assign addr_step  = (state_q == ST_HIGH) && tick;

    scan_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (addr_clear),
        .step       (addr_step),
        .peer       (cfg_q.peer),
        .frame_bits (frame_bits),
        .addr       (bit_addr),
        .out_phase  (out_phase),
        .last       (last)
    );

    assign chan_clear = (state_d == ST_IDLE);
    assign chan_adv   = (state_q == ST_HIGH) && tick && last && (state_d == ST_SYNC);

    scan_chan_rot #(.CH_W(CH_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (chan_clear),
        .advance (chan_adv),
        .depth   (cfg_in.depth),
        .chan    (chan)
    );

    assign bit_is_mux = (cfg_q.mux_words != 4'd0) && ({1'b0, bit_addr} >= mux_base);
    assign bit_chan   = bit_is_mux ? chan : '0;

    // ---------------- outputs ----------------
    assign drive_phase = cfg_q.peer || out_phase;

    always_comb begin
        bus_clk_oe = 1'b0;
        out_req    = 1'b0;
        in_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SYNC: ;
            ST_LOW: begin
                bus_clk_oe = 1'b1;
                out_req    = drive_phase;
            end
            ST_HIGH: begin
                out_req  = drive_phase;
                in_valid = tick && (cfg_q.peer || !out_phase);
            end
            default: ;
        endcase
    end

    assign bus_data_oe = out_req && out_bit;
    assign in_bit      = !bus_data_in;

    // ---------------- assertions ----------------
    assign chan_lim = (CH_W+1)'(2) << cfg_q.depth;

    // R9: stopping releases both lines on the following cycle
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!bus_clk_oe && !bus_data_oe));

    // R4: the data line is only newly pulled while the clock is held low
    p_data_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_data_oe) |-> bus_clk_oe);

    // R3: a frame opens at address zero with the clock released
    p_frame_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_addr == '0) && !bus_clk_oe);

    // R8: configuration holds steady across running bus cycles
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_LOW || state_q == ST_HIGH) &&
         ($past(state_q) == ST_LOW || $past(state_q) == ST_HIGH)) |-> $stable(cfg_q));

    // R7: the reported channel is inside the configured depth
    p_chan_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, bit_chan} < chan_lim);

endmodule

// File: tb/scan_seq_top_tb.sv
`timescale 1ns/1ps
module scan_seq_top_tb_top;
    localparam int unsigned SYS = 320000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] cfg_speed = 2'd3;
    logic [3:0] cfg_size = 4'd0;
    logic       cfg_peer = 1'b0;
    logic [1:0] cfg_depth = 2'd0;
    logic [3:0] cfg_mux_words = 4'd0;
    logic       bus_clk_oe, bus_data_oe, bus_data_in, frame_start;
    logic [7:0] bit_addr;
    logic [3:0] bit_chan;
    logic       bit_is_mux, out_req, out_bit, in_valid, in_bit;
    logic       field_bit, exp_out, exp_in;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    scan_seq_top #(.SYS_CLK_HZ(SYS)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .cfg_speed(cfg_speed), .cfg_size(cfg_size), .cfg_peer(cfg_peer),
        .cfg_depth(cfg_depth), .cfg_mux_words(cfg_mux_words),
        .bus_clk_oe(bus_clk_oe), .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in),
        .frame_start(frame_start), .bit_addr(bit_addr), .bit_chan(bit_chan),
        .bit_is_mux(bit_is_mux), .out_req(out_req), .out_bit(out_bit),
        .in_valid(in_valid), .in_bit(in_bit)
    );

    // Mapper and field model: outputs and field inputs depend on address and channel
    assign exp_out     = bit_addr[1] ^ bit_addr[4] ^ bit_chan[1];
    assign out_bit     = exp_out;
    assign field_bit   = bit_addr[0] ^ bit_addr[2] ^ bit_chan[0];
    assign bus_data_in = ~(bus_data_oe | (field_bit & (cfg_peer | ~out_req)));
    assign exp_in      = field_bit | (cfg_peer & exp_out);

    // Per-frame monitor; totals roll over at each frame_start
    int m_in, m_clk, m_max, m_bad, m_base, m_chan, m_chbad, m_low, m_drv, m_ph;
    int l_in, l_clk, l_max, l_bad, l_base, l_chan, l_chbad, l_low, l_drv, l_ph, l_period;
    int low_run = 0, stamp = 0;
    logic prev_clk = 1'b0;

    always @(negedge clk) begin
        if (frame_start) begin
            l_in = m_in; l_clk = m_clk; l_max = m_max; l_bad = m_bad; l_base = m_base;
            l_chan = m_chan; l_chbad = m_chbad; l_low = m_low; l_drv = m_drv; l_ph = m_ph;
            l_period = cyc - stamp; stamp = cyc;
            m_in = 0; m_clk = 0; m_max = 0; m_bad = 0; m_base = 999;
            m_chan = 0; m_chbad = 0; m_drv = 0; m_ph = 0;
        end
        if (bus_clk_oe && !prev_clk) m_clk++;
        if (bus_clk_oe) low_run++;
        else begin
            if (prev_clk) m_low = low_run;
            low_run = 0;
        end
        if (in_valid) begin
            m_in++;
            if (int'(bit_addr) > m_max) m_max = int'(bit_addr);
            if (in_bit != exp_in) m_bad++;
            if (!cfg_peer && out_req) m_ph++;
            if (bit_is_mux) begin
                if (int'(bit_addr) < m_base) m_base = int'(bit_addr);
                m_chan = int'(bit_chan);
            end else if (bit_chan != 4'd0) m_chbad++;
        end
        if (out_req && (bus_data_oe != exp_out)) m_drv++;
        prev_clk = bus_clk_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int tc_of(input int code);
        int rate, q;
        rate = (code == 0) ? 16000 : (code == 1) ? 32000 : (code == 2) ? 50000 : 100000;
        q = SYS / (2 * rate);
        return (q == 0) ? 1 : q;
    endfunction

    task automatic wait_starts(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!frame_start) @(negedge clk);
        end
        #1;
    endtask

    task automatic start(input int spd, input int sz, input bit peer, input int dep, input int mw);
        @(negedge clk);
        cfg_speed = 2'(spd); cfg_size = 4'(sz); cfg_peer = peer;
        cfg_depth = 2'(dep); cfg_mux_words = 4'(mw);
        run_en = 1'b1;
    endtask

    task automatic stop();
        @(negedge clk);
        run_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        int bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (bus_clk_oe || bus_data_oe || frame_start || in_valid) bad++;
        end
        check("R1 idle outputs after reset", bad, 0);
        check("R1 clock released", int'(bus_clk_oe), 0);
        check("R1 data released", int'(bus_data_oe), 0);
    endtask

    task automatic t_host();
        start(3, 1, 0, 0, 0);
        wait_starts(2);
        check("R3 host frame sample count", l_in, 32);
        check("R3 host last address", l_max, 31);
        check("R4 host clock pulses", l_clk, 64);
        check("R4 host sampled values", l_bad, 0);
        check("R4 host output drive", l_drv, 0);
        check("R4 no sample in output cycle", l_ph, 0);
        stop();
    endtask

    task automatic t_peer();
        start(3, 2, 1, 0, 0);
        wait_starts(2);
        check("R5 peer sample count", l_in, 48);
        check("R5 peer clock pulses", l_clk, 48);
        check("R5 wired-OR readback", l_bad, 0);
        check("R5 peer drive", l_drv, 0);
        stop();
    endtask

    task automatic t_speeds();
        for (int s = 0; s < 4; s++) begin
            start(s, 0, 1, 0, 0);
            wait_starts(2);
            check($sformatf("R2 low half length code %0d", s), l_low, tc_of(s));
            check($sformatf("R2 frame period code %0d", s), l_period, tc_of(s) * 33);
            stop();
        end
    endtask

    task automatic t_mux();
        start(3, 3, 0, 0, 2);
        wait_starts(2);
        check("R6 mux region start", l_base, 32);
        check("R6 non-mux channel zero", l_chbad, 0);
        check("R7 first frame channel", l_chan, 0);
        wait_starts(1);
        check("R7 second frame channel", l_chan, 1);
        wait_starts(1);
        check("R7 wrap at two channels", l_chan, 0);
        stop();
        start(3, 0, 1, 1, 3);
        wait_starts(2);
        check("R6 region clamped at zero", l_base, 0);
        for (int f = 1; f < 5; f++) begin
            wait_starts(1);
            check($sformatf("R7 four-channel frame %0d", f), l_chan, f % 4);
        end
        stop();
    endtask

    task automatic t_boundary();
        start(3, 0, 0, 0, 0);
        wait_starts(1);
        repeat (10) @(negedge clk);
        cfg_size = 4'd1;
        wait_starts(1);
        check("R8 running frame keeps length", l_in, 16);
        check("R8 running frame last address", l_max, 15);
        wait_starts(1);
        check("R8 next frame takes new length", l_in, 32);
        stop();
    endtask

    task automatic t_stop();
        int pulses = 0, starts = 0;
        start(3, 1, 0, 0, 1);
        wait_starts(2);
        repeat (20) @(negedge clk);
        run_en = 1'b0;
        @(negedge clk);
        check("R9 clock released after stop", int'(bus_clk_oe), 0);
        check("R9 data released after stop", int'(bus_data_oe), 0);
        repeat (200) begin
            @(negedge clk);
            if (bus_clk_oe) pulses++;
            if (frame_start) starts++;
        end
        check("R9 no clock while stopped", pulses, 0);
        check("R9 no frame while stopped", starts, 0);
        start(3, 1, 0, 0, 1);
        wait_starts(2);
        check("R9 channel restarts at zero", l_chan, 0);
        stop();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_host();
        t_peer();
        t_speeds();
        t_mux();
        t_boundary();
        t_stop();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule